// File: doc/BRIEF.md
# Programmable Address Decode Windows

This block holds a bank of programmable address windows and decides, for each lookup address, which window (if any) claims it. Each window has a base, a size in 64 KB units, a 4-bit target identifier and an 8-bit attribute. When a window claims the address, the block returns that window's target, attribute and the outgoing address. The outgoing address is translated on the windows that carry remap hardware and passed through unchanged on the others. When no enabled window covers the address, a miss is flagged instead.

Software programs the windows over a simple word-addressed register bus with a write strobe and combinational read data. Each window owns four consecutive words: control, base, remap low and remap high. A lookup is presented with a valid strobe, and the result appears on the registered outputs in the following cycle. When windows overlap, the lowest-numbered window has priority.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset every register word of every window reads zero, and any lookup reports a miss.
- R2: The control word (word 0 of a window) holds enable in bit 0, target in bits 7:4, attribute in bits 15:8 and size-minus-one in 64 KB units in bits 31:16; bits 3:1 read back as zero.
- R3: The base word (word 1) and remap-low word (word 2) keep only bits 31:16; bits 15:0 read back as zero.
- R4: A lookup hits a window when the address bits above the window's size mask match the base bits above that mask, where the mask is {size field, 16'hFFFF}. res_valid, res_hit, res_win, res_target and res_attr appear exactly one cycle after lk_valid.
- R5: A window whose enable bit is clear never hits.
- R6: When several windows hit, the lowest-numbered one is reported.
- R7: On a miss, res_miss is high for exactly one cycle per lookup, res_hit is low, res_target and res_attr are zero and res_addr equals the lookup address.
- R8: On a hit in a window with index below NUM_REMAP, res_addr is the remap-low bits above the size mask combined with the lookup bits inside the mask.
- R9: Windows with index at or above NUM_REMAP have no remap storage: their remap-low word ignores writes and reads zero, and their hits return the lookup address unchanged.
- R10: The remap-high word (word 3) of every window ignores writes and reads zero.
- R11: A register access whose window index is at or beyond NUM_WIN is ignored on write and reads zero, and leaves every real window untouched.
- R12: A lookup issued in the same cycle as a register write is decoded against the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Word address: window index in the upper bits, word select in bits 1:0 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Lookup address |
| res_valid | output | 1 | Result valid, one cycle after lk_valid |
| res_hit | output | 1 | Lookup was claimed by a window |
| res_miss | output | 1 | Lookup was claimed by no window |
| res_win | output | $clog2(NUM_WIN) | Index of the winning window |
| res_target | output | 4 | Target identifier of the winning window |
| res_attr | output | 8 | Attribute byte of the winning window |
| res_addr | output | 32 | Outgoing address, translated or passed through |

## Verification
A register write and a lookup can land in the same clock cycle, and the write can change the very window the lookup depends on. The bench provokes this by enabling a window over an address in the same cycle that it presents a lookup to that address. It expects a miss for that lookup and a hit for an identical lookup one cycle later. This shows that decode reads the pre-write registers and that the new value takes effect on the next request.

// File: rtl/addr_win_decoder.sv
module addr_win_decoder #(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 4,
  parameter int REG_AW    = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic [REG_AW-1:0]          reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  input  logic                       lk_valid,
  input  logic [31:0]                lk_addr,
  output logic                       res_valid,
  output logic                       res_hit,
  output logic                       res_miss,
  output logic [$clog2(NUM_WIN)-1:0] res_win,
  output logic [3:0]                 res_target,
  output logic [7:0]                 res_attr,
  output logic [31:0]                res_addr
);
  localparam int WIN_W = $clog2(NUM_WIN);
  localparam int IDX_W = REG_AW - 2;

  logic [IDX_W-1:0] widx;
  logic [1:0]       woff;
  logic             in_range;

  assign widx     = reg_addr[REG_AW-1:2];
  assign woff     = reg_addr[1:0];
  assign in_range = int'(widx) < NUM_WIN;

  logic [NUM_WIN-1:0] en_q;
  logic [3:0]         tgt_q  [NUM_WIN];
  logic [7:0]         attr_q [NUM_WIN];
  logic [15:0]        size_q [NUM_WIN];
  logic [15:0]        base_q [NUM_WIN];
  logic [15:0]        remap_q[NUM_WIN];

  logic [NUM_WIN-1:0] hit;
  logic [31:0]        xlat   [NUM_WIN];
  logic [31:0]        rd_word[NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic        sel_w;
    logic [31:0] mask;

    assign sel_w = reg_wr && in_range && (int'(widx) == w);
    assign mask  = {size_q[w], 16'hFFFF};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[w]   <= 1'b0;
        tgt_q[w]  <= '0;
        attr_q[w] <= '0;
        size_q[w] <= '0;
        base_q[w] <= '0;
      end else if (sel_w) begin
        if (woff == 2'd0) begin
          en_q[w]   <= reg_wdata[0];
          tgt_q[w]  <= reg_wdata[7:4];
          attr_q[w] <= reg_wdata[15:8];
          size_q[w] <= reg_wdata[31:16];
        end
        if (woff == 2'd1) base_q[w] <= reg_wdata[31:16];
      end
    end

    if (w < NUM_REMAP) begin : g_remap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     remap_q[w] <= '0;
        else if (sel_w && woff == 2'd2) remap_q[w] <= reg_wdata[31:16];
      end
      assign xlat[w] = ({remap_q[w], 16'h0} & ~mask) | (lk_addr & mask);
    end else begin : g_pass
      assign remap_q[w] = '0;
      assign xlat[w]    = lk_addr;
    end

    assign hit[w] = en_q[w] && ((lk_addr & ~mask) == ({base_q[w], 16'h0} & ~mask));

    always_comb begin
      case (woff)
        2'd0:    rd_word[w] = {size_q[w], attr_q[w], tgt_q[w], 3'b000, en_q[w]};
        2'd1:    rd_word[w] = {base_q[w], 16'h0};
        2'd2:    rd_word[w] = {remap_q[w], 16'h0};
        default: rd_word[w] = '0;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < NUM_WIN; w++)
      if (in_range && int'(widx) == w) reg_rdata = rd_word[w];
  end

  logic             any_hit;
  logic [WIN_W-1:0] win_sel;

  always_comb begin
    any_hit = 1'b0;
    win_sel = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit[w]) begin
        any_hit = 1'b1;
        win_sel = WIN_W'(w);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_miss   <= 1'b0;
      res_win    <= '0;
      res_target <= '0;
      res_attr   <= '0;
      res_addr   <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && any_hit;
      res_miss  <= lk_valid && !any_hit;
      if (lk_valid) begin
        res_win    <= win_sel;
        res_target <= any_hit ? tgt_q[win_sel]  : 4'h0;
        res_attr   <= any_hit ? attr_q[win_sel] : 8'h0;
        res_addr   <= any_hit ? xlat[win_sel]   : lk_addr;
      end
    end
  end
endmodule

module addr_win_decoder_chk #(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 4,
  parameter int REG_AW    = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [REG_AW-1:0]          reg_addr,
  input logic [31:0]                reg_rdata,
  input logic                       lk_valid,
  input logic [31:0]                lk_addr,
  input logic                       res_valid,
  input logic                       res_hit,
  input logic                       res_miss,
  input logic [$clog2(NUM_WIN)-1:0] res_win,
  input logic [3:0]                 res_target,
  input logic [7:0]                 res_attr,
  input logic [31:0]                res_addr
);
  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);
  p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot({res_hit, res_miss}));
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !(res_hit || res_miss));
  p_miss_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid ##1 res_miss) |-> (res_target == 4'h0 && res_attr == 8'h0 && res_addr == $past(lk_addr)));
  p_passthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid ##1 (res_hit && int'(res_win) >= NUM_REMAP)) |-> res_addr == $past(lk_addr));
  p_oor_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr[REG_AW-1:2]) >= NUM_WIN) |-> reg_rdata == 32'h0);
  p_rmhi_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[1:0] == 2'd3) |-> reg_rdata == 32'h0);
  p_base_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[1:0] == 2'd1) |-> reg_rdata[15:0] == 16'h0);
endmodule

bind addr_win_decoder addr_win_decoder_chk #(
  .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .REG_AW(REG_AW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .lk_valid(lk_valid), .lk_addr(lk_addr), .res_valid(res_valid),
  .res_hit(res_hit), .res_miss(res_miss), .res_win(res_win),
  .res_target(res_target), .res_attr(res_attr), .res_addr(res_addr)
);

// File: tb/addr_win_decoder_tb_top.sv
module addr_win_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        res_valid, res_hit, res_miss;
  logic [2:0]  res_win;
  logic [3:0]  res_target;
  logic [7:0]  res_attr;
  logic [31:0] res_addr;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  addr_win_decoder #(.NUM_WIN(8), .NUM_REMAP(4), .REG_AW(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .res_valid(res_valid), .res_hit(res_hit),
    .res_miss(res_miss), .res_win(res_win), .res_target(res_target),
    .res_attr(res_attr), .res_addr(res_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int w, input int off, input logic [31:0] d);
    @(negedge clk);
    reg_addr = 6'(w * 4 + off);
    reg_wdata = d;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int w, input int off, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = 6'(w * 4 + off);
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic look(input logic [31:0] a);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [31:0] a, input int w,
                            input logic [3:0] t, input logic [7:0] at, input logic [31:0] oa);
    look(a);
    chk(req, {res_valid, res_hit, res_miss}, 3'b110);
    chk(req, 32'(res_win), 32'(w));
    chk(req, {res_target, res_attr}, {t, at});
    chk(req, res_addr, oa);
  endtask

  task automatic expect_miss(input string req, input logic [31:0] a);
    look(a);
    chk(req, {res_valid, res_hit, res_miss}, 3'b101);
    chk(req, {res_target, res_attr}, 12'h0);
    chk(req, res_addr, a);
  endtask

  task automatic t_reset_r1;
    for (int w = 0; w < 8; w++)
      for (int o = 0; o < 4; o++) rd_chk("R1", w, o, 32'h0);
    expect_miss("R1", 32'h0000_0000);
  endtask

  task automatic t_fields_r2_r3;
    wr(2, 0, 32'hABCD_5A3F);
    rd_chk("R2", 2, 0, 32'hABCD_5A31);
    wr(2, 1, 32'h1234_FFFF);
    rd_chk("R3", 2, 1, 32'h1234_0000);
    wr(1, 2, 32'h5678_ABCD);
    rd_chk("R3", 1, 2, 32'h5678_0000);
    wr(2, 0, 32'h0);
    wr(2, 1, 32'h0);
  endtask

  task automatic t_basic_hit_r4;
    wr(5, 1, 32'h2000_0000);
    wr(5, 0, 32'h000F_1121);
    expect_hit("R4", 32'h200A_BCDE, 5, 4'h2, 8'h11, 32'h200A_BCDE);
    expect_hit("R4", 32'h200F_FFFF, 5, 4'h2, 8'h11, 32'h200F_FFFF);
    expect_miss("R4", 32'h2010_0000);
    expect_miss("R4", 32'h1FFF_FFFF);
  endtask

  task automatic t_disable_r5;
    wr(5, 0, 32'h000F_1120);
    expect_miss("R5", 32'h200A_BCDE);
    wr(5, 0, 32'h000F_1121);
  endtask

  task automatic t_priority_r6;
    wr(6, 1, 32'h2000_0000);
    wr(6, 0, 32'h00FF_0431);
    expect_hit("R6", 32'h2000_1000, 5, 4'h2, 8'h11, 32'h2000_1000);
    expect_hit("R6", 32'h2050_0000, 6, 4'h3, 8'h04, 32'h2050_0000);
  endtask

  task automatic t_miss_pulse_r7;
    expect_miss("R7", 32'hF000_1234);
    @(negedge clk);
    chk("R7", {res_valid, res_hit, res_miss}, 3'b000);
  endtask

  task automatic t_remap_r8;
    wr(1, 1, 32'h4000_0000);
    wr(1, 2, 32'h8004_0000);
    wr(1, 0, 32'h0003_0771);
    expect_hit("R8", 32'h4002_1234, 1, 4'h7, 8'h07, 32'h8006_1234);
  endtask

  task automatic t_noremap_r9;
    wr(4, 2, 32'hFFFF_0000);
    rd_chk("R9", 4, 2, 32'h0);
    wr(4, 1, 32'h6000_0000);
    wr(4, 0, 32'h0000_0191);
    expect_hit("R9", 32'h6000_ABCD, 4, 4'h9, 8'h01, 32'h6000_ABCD);
  endtask

  task automatic t_remap_hi_r10;
    wr(0, 3, 32'hDEAD_BEEF);
    rd_chk("R10", 0, 3, 32'h0);
  endtask

  task automatic t_out_of_range_r11;
    wr(9, 0, 32'hFFFF_00F1);
    rd_chk("R11", 9, 0, 32'h0);
    rd_chk("R11", 1, 0, 32'h0003_0771);
    expect_hit("R11", 32'h4002_1234, 1, 4'h7, 8'h07, 32'h8006_1234);
  endtask

  task automatic t_same_cycle_r12;
    @(negedge clk);
    reg_addr = 6'(7 * 4);
    reg_wdata = 32'h0000_0AF1;
    reg_wr = 1'b1;
    lk_valid = 1'b1;
    lk_addr = 32'h0000_1234;
    @(negedge clk);
    reg_wr = 1'b0;
    lk_valid = 1'b0;
    chk("R12", {res_valid, res_hit, res_miss}, 3'b101);
    expect_hit("R12", 32'h0000_1234, 7, 4'hF, 8'h0A, 32'h0000_1234);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_r1();
    t_fields_r2_r3();
    t_basic_hit_r4();
    t_disable_r5();
    t_priority_r6();
    t_miss_pulse_r7();
    t_remap_r8();
    t_noremap_r9();
    t_remap_hi_r10();
    t_out_of_range_r11();
    t_same_cycle_r12();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule